// File: doc/BRIEF.md
# Programmable Line-Alternation Polarity Generator

This block produces the polarity-alternation signal that a passive-matrix LCD row driver uses to flip the drive polarity of its outputs. It counts lines on the falling edge of the line shift clock. It inverts its polarity output once every N lines, where N comes from a 5-bit strapped setting. Alternating every few lines instead of once per frame spreads the inversion across the panel and keeps cross-talk low. Useful settings run from 2 to 31 lines, and 10 to 31 is the recommended range.

A setting of zero turns generation off. The polarity pin then becomes an input, the output enable drops, and the externally supplied polarity is passed straight through to the internal output selector. A setting of one is not a legal configuration. In that case the polarity holds still and an error flag is raised. The setting is captured while reset is low. A change made while the block runs only takes effect when the current half-period ends.

Top module: `line_alt_gen`

## Requirements
- R1: With an active setting N from 2 to 31 (the 5-bit `period_sel` read as an unsigned binary number), `m_out` inverts exactly once every N falling edges of `line_clk` and stays unchanged on every other edge.
- R2: With an active setting of 0, `m_oe` is 0 and `m_int` equals `m_pin_in` combinationally, with no clock edge in between.
- R3: With an active setting of 1, `cfg_err` is 1, `m_oe` is 1 and `m_out` holds its value on every edge.
- R4: `cfg_err` is 0 whenever the active setting is not 1.
- R5: Reset is synchronous and active low, and is sampled on the falling edge of `line_clk`. A reset edge clears the line count, sets `m_out` to 0 and makes the current `period_sel` the active setting.
- R6: After reset is released with an active setting N of at least 2, the first inversion of `m_out` happens on exactly the N-th falling edge.
- R7: A change to `period_sel` while counting does not affect the half-period in progress. The new value becomes active on the edge where `m_out` inverts, and it governs the half-period that follows.
- R8: While the active setting is 0 or 1, `period_sel` is re-read on every falling edge. When a counting setting N is loaded this way, `m_out` resumes from its held value and first inverts N edges after the loading edge.
- R9: While generating (`m_oe` is 1), `m_int` equals `m_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Line shift clock; lines are counted on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset of the alternation logic |
| period_sel | input | 5 | Strapped half-period setting in lines (0 = external, 1 = illegal) |
| m_pin_in | input | 1 | Value read from the bidirectional polarity pin |
| m_out | output | 1 | Internally generated polarity, driven onto the pin |
| m_oe | output | 1 | Output enable of the polarity pin driver |
| m_int | output | 1 | Polarity used by the row output level selector |
| cfg_err | output | 1 | High while the active setting is the illegal value 1 |

## Verification
The generator is first run at fixed settings of 3, 31 and 2. At each one the bench measures the length of every half-period, which separates an off-by-one count or a wrong wrap point from correct behaviour. The setting is then changed in the middle of a half-period, so that a block that takes the change at once can be told apart from one that waits for the wrap. The bench also walks the setting through the illegal value, the external value and back to a counting value. This shows whether M holds, whether the pin passes through combinationally, and whether counting restarts from zero. A long pseudo-random run follows, with setting changes, pin toggles and resets in the middle of operation, compared edge by edge against a behavioural model.

// File: rtl/line_alt_pkg.sv
// Shared types for the line-alternation polarity generator.
// Assumes: the setting field width is a parameter of the user modules.
package line_alt_pkg;

    // Operating mode decoded from the active half-period setting
    typedef enum logic [1:0] {
        MODE_EXT     = 2'd0,   // setting 0: polarity comes from the pin
        MODE_ILLEGAL = 2'd1,   // setting 1: prohibited, hold polarity
        MODE_COUNT   = 2'd2    // setting 2..max: internal generation
    } alt_mode_e;

endpackage

// File: rtl/line_alt_decode.sv
// Decodes the active half-period setting into an operating mode.
// Assumes: purely combinational; the setting is already registered.
module line_alt_decode
    import line_alt_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic [SEL_W-1:0] active_sel,
    output alt_mode_e        mode
);

    localparam logic [SEL_W-1:0] SEL_EXT = '0;
    localparam logic [SEL_W-1:0] SEL_ILL = SEL_W'(1);

    // Map the setting value onto one of the three modes
    always_comb begin
        if (active_sel == SEL_EXT)
            mode = MODE_EXT;
        else if (active_sel == SEL_ILL)
            mode = MODE_ILLEGAL;
        else
            mode = MODE_COUNT;
    end

endmodule

// File: rtl/line_alt_counter.sv
// Counts lines and owns the active setting register.
// Assumes: clocked on the falling edge of the line clock, synchronous
// active-low reset. Outside counting mode every edge is a wrap point,
// so the setting is re-read on each line.
module line_alt_counter
    import line_alt_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic             line_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] period_sel,
    input  alt_mode_e        mode,
    output logic [SEL_W-1:0] active_sel,
    output logic             wrap
);

    localparam logic [SEL_W-1:0] ONE = SEL_W'(1);

    logic [SEL_W-1:0] line_cnt;

    // Wrap when the last line of the half-period is reached, or always when idle
    always_comb begin
        wrap = (mode != MODE_COUNT) || (line_cnt == (active_sel - ONE));
    end

    // Advance the line count and reload the setting at each wrap
    always_ff @(negedge line_clk) begin
        if (!rst_n) begin
            line_cnt   <= '0;
            active_sel <= period_sel;
        end else if (wrap) begin
            line_cnt   <= '0;
            active_sel <= period_sel;
        end else begin
            line_cnt   <= line_cnt + ONE;
        end
    end

    // R1: the count never leaves the current half-period
    p_cnt_bound_r1: assert property (@(negedge line_clk) disable iff (!rst_n)
        (mode == MODE_COUNT) |-> (line_cnt < active_sel));

    // R7: the setting cannot change in the middle of a half-period
    p_sel_hold_r7: assert property (@(negedge line_clk) disable iff (!rst_n)
        (mode == MODE_COUNT && !wrap) |=> $stable(active_sel));

    // R5: leaving reset starts from line zero
    p_cnt_reset_r5: assert property (@(negedge line_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (line_cnt == '0));

endmodule

// File: rtl/line_alt_polarity.sv
// Holds the generated polarity bit and inverts it at each counting wrap.
// Assumes: falling-edge line clock, synchronous active-low reset.
module line_alt_polarity
    import line_alt_pkg::*;
(
    input  logic      line_clk,
    input  logic      rst_n,
    input  alt_mode_e mode,
    input  logic      wrap,
    output logic      m_gen
);

    logic flip;

    // Invert only when a counting half-period completes
    always_comb begin
        flip = (mode == MODE_COUNT) && wrap;
    end

    // Polarity register: cleared by reset, toggled on flip
    always_ff @(negedge line_clk) begin
        if (!rst_n)
            m_gen <= 1'b0;
        else if (flip)
            m_gen <= ~m_gen;
    end

    // R1: inversion happens exactly at a counting wrap
    p_flip_r1: assert property (@(negedge line_clk) disable iff (!rst_n)
        (mode == MODE_COUNT && wrap) |=> (m_gen != $past(m_gen)));

    // R1: no inversion away from a counting wrap
    p_steady_r1: assert property (@(negedge line_clk) disable iff (!rst_n)
        !(mode == MODE_COUNT && wrap) |=> $stable(m_gen));

    // R3: the illegal setting freezes the polarity
    p_err_hold_r3: assert property (@(negedge line_clk) disable iff (!rst_n)
        (mode == MODE_ILLEGAL) |=> $stable(m_gen));

    // R5: polarity starts at zero after reset
    p_m_reset_r5: assert property (@(negedge line_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (m_gen == 1'b0));

endmodule

// File: rtl/line_alt_gen.sv
// Top level of the line-alternation polarity generator. Chooses between
// the generated polarity and the pin value, and drives the pin enable and
// the illegal-setting flag.
// Assumes: line_clk is the line shift clock; all state changes on its
// falling edge.
module line_alt_gen
    import line_alt_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic             line_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             m_pin_in,
    output logic             m_out,
    output logic             m_oe,
    output logic             m_int,
    output logic             cfg_err
);

    logic [SEL_W-1:0] active_sel;
    alt_mode_e        mode;
    logic             wrap;
    logic             m_gen;

    line_alt_decode #(.SEL_W(SEL_W)) u_decode (
        .active_sel (active_sel),
        .mode       (mode)
    );

    line_alt_counter #(.SEL_W(SEL_W)) u_counter (
        .line_clk   (line_clk),
        .rst_n      (rst_n),
        .period_sel (period_sel),
        .mode       (mode),
        .active_sel (active_sel),
        .wrap       (wrap)
    );

    line_alt_polarity u_polarity (
        .line_clk (line_clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .wrap     (wrap),
        .m_gen    (m_gen)
    );

    // Pin direction, selector source and error flag from the current mode
    always_comb begin
        m_out   = m_gen;
        m_oe    = (mode != MODE_EXT);
        m_int   = (mode == MODE_EXT) ? m_pin_in : m_gen;
        cfg_err = (mode == MODE_ILLEGAL);
    end

    // R2: external mode passes the pin through with the driver off
    p_ext_pass_r2: assert property (@(negedge line_clk) disable iff (!rst_n)
        !m_oe |-> (m_int == m_pin_in));

    // R9: while driving, the selector sees the driven value
    p_int_follow_r9: assert property (@(negedge line_clk) disable iff (!rst_n)
        m_oe |-> (m_int == m_out));

    // R4: the error flag implies the driver stays on
    p_err_oe_r4: assert property (@(negedge line_clk) disable iff (!rst_n)
        cfg_err |-> m_oe);

endmodule

// File: tb/sim_line_alt_gen.sv
`timescale 1ns/1ps
module sim_line_alt_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] period_sel = 5'd3;
    logic       m_pin_in = 1'b0;
    logic       m_out, m_oe, m_int, cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int ref_cnt = 0;
    int ref_sel = 0;
    bit ref_m   = 1'b0;

    always #4 clk = ~clk;

    line_alt_gen u0 (
        .line_clk   (clk),
        .rst_n      (rst_n),
        .period_sel (period_sel),
        .m_pin_in   (m_pin_in),
        .m_out      (m_out),
        .m_oe       (m_oe),
        .m_int      (m_int),
        .cfg_err    (cfg_err)
    );

    task automatic check(input string tag, input bit ok, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // compare every output with the model
    task automatic compare(input string tag);
        bit e_oe, e_int, e_err;
        e_oe  = (ref_sel != 0);
        e_int = (ref_sel == 0) ? m_pin_in : ref_m;
        e_err = (ref_sel == 1);
        check(tag, (m_out === ref_m) && (m_oe === e_oe) && (m_int === e_int) && (cfg_err === e_err),
              $sformatf("out/oe/int/err actual %b%b%b%b expected %b%b%b%b",
                        m_out, m_oe, m_int, cfg_err, ref_m, e_oe, e_int, e_err));
    endtask

    // one falling edge: model update, then compare
    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) begin
            ref_cnt = 0; ref_sel = period_sel; ref_m = 1'b0;
        end else if (ref_sel < 2 || ref_cnt == ref_sel - 1) begin
            if (ref_sel >= 2) ref_m = !ref_m;
            ref_cnt = 0; ref_sel = period_sel;
        end else begin
            ref_cnt++;
        end
        #1;
        compare(tag);
    endtask

    // steps until m_out changes, returns the number of edges taken
    task automatic until_flip(input string tag, output int n);
        bit prev;
        prev = m_out;
        n = 0;
        do begin
            step(tag);
            n++;
        end while (m_out == prev && n < 40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        // R5: reset state
        rst_n = 1'b0; period_sel = 5'd3;
        for (int i = 0; i < 3; i++) step("R5");
        check("R5", m_out == 0 && m_oe == 1 && cfg_err == 0,
              $sformatf("reset out/oe/err actual %b%b%b expected 010", m_out, m_oe, cfg_err));

        // R6: first inversion after N edges
        rst_n = 1'b1;
        until_flip("R6", n);
        check("R6", n == 3, $sformatf("first half-period actual %0d expected 3", n));
        until_flip("R1", n);
        check("R1", n == 3, $sformatf("half-period N=3 actual %0d expected 3", n));

        // R7: change mid-run applies after the current half-period
        step("R7");
        period_sel = 5'd31;
        until_flip("R7", n);
        check("R7", n == 2, $sformatf("in-progress half actual %0d expected 2", n));
        until_flip("R1", n);
        check("R1", n == 31, $sformatf("half-period N=31 actual %0d expected 31", n));
        period_sel = 5'd2;
        until_flip("R7", n);
        check("R7", n == 31, $sformatf("old setting half actual %0d expected 31", n));
        until_flip("R1", n);
        check("R1", n == 2, $sformatf("half-period N=2 actual %0d expected 2", n));

        // R3/R4: illegal setting holds polarity
        period_sel = 5'd1;
        until_flip("R3", n);
        check("R3", n == 2, $sformatf("half before illegal actual %0d expected 2", n));
        for (int i = 0; i < 10; i++) step("R3");
        check("R3", cfg_err == 1 && m_oe == 1 && m_out == ref_m,
              $sformatf("illegal err/oe/out actual %b%b%b expected 11%b", cfg_err, m_oe, m_out, ref_m));

        // R8/R2: external mode loaded on the next edge, pin passes through
        period_sel = 5'd0;
        step("R8");
        check("R4", cfg_err == 0 && m_oe == 0,
              $sformatf("ext err/oe actual %b%b expected 00", cfg_err, m_oe));
        for (int i = 0; i < 4; i++) begin
            m_pin_in = ~m_pin_in;
            #1;
            check("R2", m_int == m_pin_in, $sformatf("pass-through actual %b expected %b", m_int, m_pin_in));
            step("R2");
        end

        // R8: counting resumes N edges after the loading edge
        period_sel = 5'd6;
        step("R8");
        check("R8", m_oe == 1, $sformatf("oe after load actual %b expected 1", m_oe));
        until_flip("R8", n);
        check("R8", n == 6, $sformatf("resume half-period actual %0d expected 6", n));

        // R5: reset mid-run into external mode
        rst_n = 1'b0; period_sel = 5'd0;
        step("R5");
        check("R5", m_out == 0 && m_oe == 0, $sformatf("reset ext out/oe actual %b%b expected 00", m_out, m_oe));
        rst_n = 1'b1;

        // R1/R9: mixed pseudo-random run
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 39) == 0) period_sel = 5'($urandom_range(0, 31));
            if ($urandom_range(0, 3) == 0)  m_pin_in = ~m_pin_in;
            rst_n = ($urandom_range(0, 299) != 0);
            step("R9");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule